// File: doc/BRIEF.md
# Approximate Floating-Point Multiplier by Integer Addition

This block gives an approximate product of two binary floating-point words without a fraction multiplier. It reads each operand's exponent-and-fraction field as an unsigned integer and adds the two integers. It then subtracts the integer pattern of 1.0, which removes the doubled exponent bias. The result is a piecewise-linear approximation of the product in the log domain. It never exceeds the exact product and is off by at most about one ninth of it. The result sign is the exclusive-or of the operand signs.

Special operands bypass the adder, and so does a corrected exponent that leaves the normal range. NaN inputs, and infinity times zero, give a canonical quiet NaN. Infinity times any other value gives a signed infinity. Zero and subnormal inputs give a signed zero. When the corrected exponent is too large the result saturates to infinity, and when it is too small the result flushes to zero. The result is registered: it appears one clock after a request, together with a one-cycle valid strobe. The output word keeps its last value while no request arrives.

Top module: `fp_logadd_mul`

## Requirements
- R1: For two normal operands, when the corrected exponent stays in range, the result is the sign XOR followed by the low 31 bits of (magA + magB - 0x3F800000). Here mag is bits [30:0], sign is bit 31, the exponent is bits [30:23] and the fraction is bits [22:0].
- R2: outValid is high exactly in the cycle after a cycle with inValid high, and outData changes only at a clock that follows an inValid cycle.
- R3: When (magA + magB - 0x3F800000) taken as a signed value, shifted right by 23, is 255 or more, the result is signed infinity (sign XOR, 0x7F800000).
- R4: When that shifted value is 0 or below, the result is signed zero (sign XOR, all other bits 0).
- R5: An operand with exponent field 0 (zero or subnormal) times a finite operand gives signed zero.
- R6: A NaN operand (exponent 255, fraction nonzero), or infinity times zero, gives 0x7FC00000. This case has priority over every other case.
- R7: Infinity (exponent 255, fraction 0) times a nonzero finite value or another infinity gives signed infinity.
- R8: While reset is active and right after it is released, outValid is 0 and outData is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request strobe; the operands are sampled at this clock |
| opA | input | 32 | First operand, binary32 layout |
| opB | input | 32 | Second operand, binary32 layout |
| outValid | output | 1 | Result strobe, one cycle after inValid |
| outData | output | 32 | Registered approximate product |

## Verification
Two functions can fire together in one evaluation: range saturation from the adder path and special-operand resolution. An example is infinity times a huge finite value, where both the overflow test and the infinity rule apply. Another is a subnormal times a tiny normal, where both the underflow test and the zero rule apply. The worst collision is NaN against a value that would overflow. Directed pairs build each collision, and a random stream weighted toward extreme exponents builds more. Each result is judged against a behavioural reference that applies NaN first, then infinity, then zero, then range. Back-to-back requests with idle gaps between them also check the valid alignment and the hold of the output word.

// File: rtl/fplog_pkg.sv
package fplog_pkg;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NORM = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } opClass_t;

  // strobes handed from control to datapath
  typedef struct packed {
    logic load;
    logic selNan;
    logic selInf;
    logic selZero;
    logic signOut;
  } ctrlStrobes_t;

endpackage

// File: rtl/fplog_ctrl.sv
module fplog_ctrl
  import fplog_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                        inValid,
  input  logic [EXP_W+FRAC_W:0]       opA,
  input  logic [EXP_W+FRAC_W:0]       opB,
  output ctrlStrobes_t                strb
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int N_OPS  = 2;

  logic [N_OPS-1:0][WORD_W-1:0] ops;
  logic [EXP_W-1:0]             expField [N_OPS];
  logic                         fracZero [N_OPS];
  opClass_t                     opClass  [N_OPS];

  assign ops[0] = opA;
  assign ops[1] = opB;

  // per-operand classifier, subnormals fold into zero
  for (genvar g = 0; g < N_OPS; g++) begin : gClass
    assign expField[g] = ops[g][WORD_W-2 -: EXP_W];
    assign fracZero[g] = (ops[g][FRAC_W-1:0] == '0);
    assign opClass[g]  = (expField[g] == '1) ? (fracZero[g] ? CLS_INF : CLS_NAN)
                       : (expField[g] == '0) ? CLS_ZERO : CLS_NORM;
  end

  logic anyNan, anyInf, anyZero;

  always_comb begin
    anyNan  = (opClass[0] == CLS_NAN)  || (opClass[1] == CLS_NAN);
    anyInf  = (opClass[0] == CLS_INF)  || (opClass[1] == CLS_INF);
    anyZero = (opClass[0] == CLS_ZERO) || (opClass[1] == CLS_ZERO);
    strb.load    = inValid;
    strb.selNan  = anyNan || (anyInf && anyZero);
    strb.selInf  = !strb.selNan && anyInf;
    strb.selZero = !strb.selNan && !anyInf && anyZero;
    strb.signOut = opA[WORD_W-1] ^ opB[WORD_W-1];
  end

endmodule

// File: rtl/fplog_dp.sv
module fplog_dp
  import fplog_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [EXP_W+FRAC_W:0]  opA,
  input  logic [EXP_W+FRAC_W:0]  opB,
  input  ctrlStrobes_t           strb,
  output logic                   outValid,
  output logic [EXP_W+FRAC_W:0]  outData
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int MAG_W  = EXP_W + FRAC_W;
  localparam int SUM_W  = MAG_W + 2;
  localparam int TOP_W  = SUM_W - FRAC_W;
  localparam logic [EXP_W-1:0] BIAS_V  = {1'b0, {(EXP_W-1){1'b1}}};
  localparam logic [SUM_W-1:0] ONE_PAT = {2'b00, BIAS_V, {FRAC_W{1'b0}}};
  localparam logic [TOP_W-1:0] EXP_MAX = {2'b00, {EXP_W{1'b1}}};
  localparam logic [WORD_W-1:0] QNAN   = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [SUM_W-1:0] corrSum;
  logic [TOP_W-1:0] topExp;
  logic             underRange, overRange;
  logic [WORD_W-1:0] resWord;

  // integer add of the magnitude fields, then remove one bias
  assign corrSum    = {2'b00, opA[MAG_W-1:0]} + {2'b00, opB[MAG_W-1:0]} - ONE_PAT;
  assign topExp     = corrSum[SUM_W-1:FRAC_W];
  assign underRange = topExp[TOP_W-1] || (topExp == '0);
  assign overRange  = !underRange && (topExp >= EXP_MAX);

  always_comb begin
    if (strb.selNan)
      resWord = QNAN;
    else if (strb.selInf || (!strb.selZero && overRange))
      resWord = {strb.signOut, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (strb.selZero || underRange)
      resWord = {strb.signOut, {MAG_W{1'b0}}};
    else
      resWord = {strb.signOut, corrSum[MAG_W-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= strb.load;
      if (strb.load) outData <= resWord;
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> outValid);
  // R2
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> !outValid);
  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(outData));
  // R6
  nan_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.selNan) |=> (outData == QNAN));
  // R3
  overflow_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.selNan && !strb.selZero && overRange)
      |=> (outData[MAG_W-1:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));
  // R4
  underflow_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.selNan && !strb.selInf && underRange)
      |=> (outData[MAG_W-1:0] == '0));
  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> $onehot0({strb.selNan, strb.selInf, strb.selZero}));

endmodule

// File: rtl/fp_logadd_mul.sv
module fp_logadd_mul
  import fplog_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [EXP_W+FRAC_W:0] opA,
  input  logic [EXP_W+FRAC_W:0] opB,
  output logic                  outValid,
  output logic [EXP_W+FRAC_W:0] outData
);
  ctrlStrobes_t strb;

  fplog_ctrl #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) uCtrl (
    .inValid (inValid),
    .opA     (opA),
    .opB     (opB),
    .strb    (strb)
  );

  fplog_dp #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .opA      (opA),
    .opB      (opB),
    .strb     (strb),
    .outValid (outValid),
    .outData  (outData)
  );

endmodule

// File: tb/tb_fp_logadd_mul.sv
`timescale 1ns/1ps
module tb_fp_logadd_mul;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        outValid;
  logic [31:0] outData;

  int compared = 0;
  int mismatched = 0;
  logic        expValid = 1'b0;
  logic [31:0] expData = '0;
  string       expTag = "R8";
  logic [31:0] rngState = 32'h1234_5678;

  always #2.5 clk = ~clk;

  fp_logadd_mul dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .outValid(outValid), .outData(outData)
  );

  // behavioural reference: priority NaN, infinity, zero, then range
  function automatic logic [31:0] refMul(input logic [31:0] a, input logic [31:0] b,
                                         output string tag);
    longint ea, eb, c, ce;
    bit nanA, nanB, infA, infB, zA, zB;
    logic s;
    ea = longint'(a[30:23]); eb = longint'(b[30:23]);
    nanA = (ea == 255) && (a[22:0] != 0); nanB = (eb == 255) && (b[22:0] != 0);
    infA = (ea == 255) && (a[22:0] == 0); infB = (eb == 255) && (b[22:0] == 0);
    zA = (ea == 0); zB = (eb == 0);
    s = a[31] ^ b[31];
    if (nanA || nanB || (infA && zB) || (zA && infB)) begin
      tag = "R6"; return 32'h7FC0_0000;
    end
    if (infA || infB) begin tag = "R7"; return {s, 31'h7F80_0000}; end
    if (zA || zB) begin tag = "R5"; return {s, 31'h0}; end
    c = longint'(a[30:0]) + longint'(b[30:0]) - 64'h3F80_0000;
    ce = c >>> 23;
    if (ce <= 0) begin tag = "R4"; return {s, 31'h0}; end
    if (ce >= 255) begin tag = "R3"; return {s, 31'h7F80_0000}; end
    tag = "R1";
    return {s, c[30:0]};
  endfunction

  task automatic compareNow();
    compared++;
    if (outValid !== expValid) begin
      mismatched++;
      $display("FAIL R2 outValid actual=%0b expected=%0b", outValid, expValid);
    end
    compared++;
    if (outData !== expData) begin
      mismatched++;
      $display("FAIL %s outData actual=%08h expected=%08h", expTag, outData, expData);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] a, input logic [31:0] b);
    string tg;
    @(negedge clk);
    compareNow();
    inValid = v; opA = a; opB = b;
    expValid = v;
    if (v) begin
      expData = refMul(a, b, tg);
      expTag = tg;
    end else if (expTag.len() > 0) begin
      expTag = "R2";
    end
  endtask

  function automatic logic [31:0] nextRnd();
    rngState ^= rngState << 13;
    rngState ^= rngState >> 17;
    rngState ^= rngState << 5;
    return rngState;
  endfunction

  function automatic logic [31:0] pickOperand(input logic [31:0] r, input logic [31:0] q);
    logic [7:0] e;
    case (q[2:0])
      3'd0: e = 8'd0;
      3'd1: e = 8'd255;
      3'd2: e = 8'd254 - {5'd0, q[5:3]};
      3'd3: e = 8'd1 + {5'd0, q[5:3]};
      default: e = r[30:23];
    endcase
    if (q[8:6] == 3'd0) return {r[31], e, 23'd0};
    return {r[31], e, r[22:0]};
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R8 reset state while held in reset
    repeat (3) @(negedge clk);
    compareNow();
    rstN = 1'b1;
    // R1 exact-power and midpoint cases
    drive(1, 32'h3F80_0000, 32'h3F80_0000);
    drive(1, 32'h4000_0000, 32'h4040_0000);
    drive(1, 32'h3FC0_0000, 32'hBFC0_0000);
    drive(0, 32'hDEAD_BEEF, 32'h1234_5678);   // R2 idle, output holds
    drive(0, 32'h0, 32'h0);
    drive(1, 32'h7F7F_FFFF, 32'h3F80_0000);   // R1 top of range
    drive(1, 32'h0080_0000, 32'h3F80_0000);   // R1 bottom of range
    drive(1, 32'h7F7F_FFFF, 32'h3F80_0001);   // R3 just over
    drive(1, 32'hFF00_0000, 32'h7F00_0000);   // R3 negative
    drive(1, 32'h0080_0000, 32'h3F7F_FFFF);   // R4 just under
    drive(1, 32'h8080_0000, 32'h0080_0000);   // R4 negative
    drive(1, 32'h0000_0001, 32'h4000_0000);   // R5 subnormal
    drive(1, 32'h8000_0000, 32'h7F7F_FFFF);   // R5 zero vs huge
    drive(1, 32'h7FC0_0001, 32'h3F80_0000);   // R6 NaN
    drive(1, 32'h7F80_0000, 32'h8000_0000);   // R6 inf times zero
    drive(1, 32'h7F80_0001, 32'h7F80_0000);   // R6 NaN beats inf
    drive(1, 32'hFF80_0000, 32'h4000_0000);   // R7
    drive(1, 32'h7F80_0000, 32'hFF80_0000);   // R7 inf times inf
    drive(1, 32'h7F80_0000, 32'h0080_0000);   // R7 inf times tiny
    drive(0, 32'h0, 32'h0);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r1, r2, q;
      r1 = nextRnd(); r2 = nextRnd(); q = nextRnd();
      drive(q[31:29] != 3'd0, pickOperand(r1, q), pickOperand(r2, q >> 9));
    end
    drive(0, 32'h0, 32'h0);
    drive(0, 32'h0, 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule